// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Transmitter

This block sends one asynchronous serial character on a single output wire each time it accepts a send request. A character frame starts with a start bit. The data bits follow, then an optional parity bit, then one stop bit. Every bit is held for `CLKS_PER_BIT` clock cycles. Four run-time configuration inputs set the frame shape:

- line polarity: normal or inverted;
- bit order: least significant or most significant bit first;
- data length: 7 or 8 bits;
- parity: none, even or odd.

The block captures the data byte and every configuration input when it accepts a request. Changes to those inputs during a frame therefore have no effect.

The behaviour is described in terms of two logical line states. ON is the idle, stop and data-1 level. OFF is the start and data-0 level. The polarity setting maps ON to a physical level: high in normal mode, low in inverted mode.

The controller is a state machine with five states:

- `ST_IDLE`: waits for a request.
- `ST_START`: sends the start bit.
- `ST_DATA`: sends the data bits.
- `ST_PARITY`: sends the parity bit.
- `ST_STOP`: sends the stop bit.

The transitions are:

- IDLE→START when a send is accepted.
- START→DATA at the end of the start bit.
- DATA→DATA after each data bit except the last.
- DATA→PARITY after the last data bit when parity is enabled.
- DATA→STOP after the last data bit when parity is disabled.
- PARITY→STOP at the end of the parity bit.
- STOP→IDLE at the end of the stop bit.

A bit timer reloads at every bit boundary and raises a one-cycle tick that advances the machine.

Top module: `frame_tx`

## Requirements
- R1: An accepted frame consists of a start bit, then the data bits, then a parity bit if enabled, then one stop bit. Each bit lasts exactly `CLKS_PER_BIT` cycles. `tx_busy` is high for (2 + data bits + parity bits) × `CLKS_PER_BIT` cycles.
- R2: The line is ON when idle, OFF during the start bit, ON during the stop bit, and ON for a data 1 and OFF for a data 0.
- R3: With `cfg_invert`=0, ON is a high line and OFF is a low line. With `cfg_invert`=1, ON is low and OFF is high. While idle, the line follows `cfg_invert` one cycle later.
- R4: With `cfg_msb_first`=0, data bit 0 is sent first and the bits go out in ascending order.
- R5: With `cfg_msb_first`=1, the top data bit is sent first: bit 7 in 8-bit mode, bit 6 in 7-bit mode. The bits go out in descending order.
- R6: With `cfg_seven_bit`=1, only bits 6..0 are sent (7 data bits). Input bit 7 has no effect on the line or on parity.
- R7: `cfg_parity` encoding: 2'b01 selects even parity, 2'b10 selects odd parity, and 2'b00 and 2'b11 select no parity. The parity bit is ON when the number of ones among the sent data bits is odd (even parity) or even (odd parity). The total count of ones is then even or odd respectively.
- R8: With no parity, the stop bit directly follows the last data bit.
- R9: `tx_send` is accepted only on a clock edge where `tx_busy` is low. `tx_busy` is high in the cycle after acceptance.
- R10: `tx_send` while busy is ignored. Changes to `tx_data` or to any `cfg_*` input after acceptance do not alter the frame in progress.
- R11: After reset, `tx_busy` is low and `tx_line` is high (idle ON, normal polarity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Character to send |
| tx_send | input | 1 | Send request, accepted when not busy |
| cfg_invert | input | 1 | 1 = inverted line polarity |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_seven_bit | input | 1 | 1 = 7 data bits |
| cfg_parity | input | 2 | 01 even, 10 odd, 00/11 none |
| tx_busy | output | 1 | High from acceptance to end of stop bit |
| tx_line | output | 1 | Serial output line |

## Verification
The assertions check the following on every cycle:

- a request seen while idle raises busy on the next cycle;
- the first level of a frame is the OFF level for the polarity captured at acceptance;
- the line changes only at bit-timer ticks while busy;
- busy falls only on a tick;
- the busy span matches the frame length implied by the captured data length and parity mode;
- the idle level tracks the polarity input.

Only the bench scenarios can show the following, because they sample each bit centre against an expected frame:

- the value of each data bit in both bit orders;
- that bit 7 is ignored in 7-bit mode;
- the parity value for even and odd modes;
- that changes to the data and configuration inputs in mid-frame are ignored.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
    localparam int DATA_MAX = 8;
    localparam int IDX_W    = $clog2(DATA_MAX);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } state_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF2 = 2'b11
    } parity_t;
endpackage

// File: rtl/frame_tx_baud.sv
module frame_tx_baud #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/frame_tx_shaper.sv
module frame_tx_shaper
    import frame_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [DATA_MAX-1:0] data,
    input  logic                msb_first,
    input  logic                seven_bit,
    input  logic                odd_par,
    output logic                cur_bit,
    output logic                par_on
);
    logic [DATA_MAX-1:0] ordered;
    logic [DATA_MAX-1:0] masked;
    logic [DATA_MAX-1:0] sh_q;
    logic                par_q;

    // Reorder so that the first bit on the wire sits in position 0.
    always_comb begin
        masked  = seven_bit ? {1'b0, data[DATA_MAX-2:0]} : data;
        ordered = masked;
        if (msb_first) begin
            for (int i = 0; i < DATA_MAX; i++) begin
                if (seven_bit) begin
                    ordered[i] = (i < DATA_MAX - 1) ? masked[DATA_MAX-2-i] : 1'b0;
                end else begin
                    ordered[i] = masked[DATA_MAX-1-i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= ordered;
            par_q <= (^masked) ^ odd_par;
        end else if (shift) begin
            sh_q  <= {1'b0, sh_q[DATA_MAX-1:1]};
        end
    end

    assign cur_bit = sh_q[0];
    assign par_on  = par_q;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_send,
    input  logic       cfg_invert,
    input  logic       cfg_msb_first,
    input  logic       cfg_seven_bit,
    input  logic [1:0] cfg_parity,
    output logic       tx_busy,
    output logic       tx_line
);
    state_t           state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             seven_q, haspar_q, pol_q;
    logic             accept, tick, cur_bit, par_on, on_lvl, last_bit;

    assign accept   = tx_send && (state_q == ST_IDLE);
    assign last_bit = (idx_q == (seven_q ? IDX_W'(DATA_MAX - 2) : IDX_W'(DATA_MAX - 1)));

    frame_tx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    frame_tx_shaper u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .shift     (tick && (state_q == ST_DATA)),
        .data      (tx_data),
        .msb_first (cfg_msb_first),
        .seven_bit (cfg_seven_bit),
        .odd_par   (cfg_parity == PAR_ODD),
        .cur_bit   (cur_bit),
        .par_on    (par_on)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_START;
            ST_START:  if (tick) state_d = ST_DATA;
            ST_DATA:   if (tick && last_bit) state_d = haspar_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick) state_d = ST_STOP;
            ST_STOP:   if (tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit index and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            seven_q  <= 1'b0;
            haspar_q <= 1'b0;
            pol_q    <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            pol_q <= cfg_invert;
            if (accept) begin
                idx_q    <= '0;
                seven_q  <= cfg_seven_bit;
                haspar_q <= (cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD);
            end
        end else if (tick && (state_q == ST_DATA)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   on_lvl = 1'b1;
            ST_START:  on_lvl = 1'b0;
            ST_DATA:   on_lvl = cur_bit;
            ST_PARITY: on_lvl = par_on;
            ST_STOP:   on_lvl = 1'b1;
            default:   on_lvl = 1'b1;
        endcase
        tx_line = on_lvl ^ pol_q;
        tx_busy = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/frame_tx_checker.sv
module frame_tx_checker #(
    parameter int CLKS_PER_BIT = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_send,
    input logic       tx_busy,
    input logic       tx_line,
    input logic       cfg_invert,
    input logic       cfg_seven_bit,
    input logic [1:0] cfg_parity,
    input logic       bit_tick
);
    logic [15:0] busy_cnt;
    logic        cap_seven, cap_par;
    int          exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt  <= '0;
            cap_seven <= 1'b0;
            cap_par   <= 1'b0;
        end else begin
            busy_cnt <= tx_busy ? busy_cnt + 1'b1 : '0;
            if (tx_send && !tx_busy) begin
                cap_seven <= cfg_seven_bit;
                cap_par   <= (cfg_parity == 2'b01) || (cfg_parity == 2'b10);
            end
        end
    end

    assign exp_len = CLKS_PER_BIT * (2 + (cap_seven ? 7 : 8) + (cap_par ? 1 : 0));

    // R9: acceptance raises busy next cycle
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && !tx_busy) |=> tx_busy);

    // R2: start bit is OFF at the captured polarity
    p_start_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (tx_line == $past(cfg_invert)));

    // R1: line changes only at bit boundaries
    p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy) && !$past(bit_tick)) |-> $stable(tx_line));

    // R1: busy ends on a bit boundary
    p_busy_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(bit_tick));

    // R8: frame length matches the captured shape
    p_frame_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> (int'(busy_cnt) == exp_len));

    // R3: idle level follows polarity
    p_idle_pol_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && $past(!tx_busy)) |-> (tx_line == !$past(cfg_invert)));
endmodule

bind frame_tx frame_tx_checker #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_send       (tx_send),
    .tx_busy       (tx_busy),
    .tx_line       (tx_line),
    .cfg_invert    (cfg_invert),
    .cfg_seven_bit (cfg_seven_bit),
    .cfg_parity    (cfg_parity),
    .bit_tick      (tick)
);

// File: tb/frame_tx_test.sv
`timescale 1ns/1ps
module frame_tx_test;
    localparam int C = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_send = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_seven_bit = 1'b0;
    logic [1:0] cfg_parity = 2'b00;
    logic       tx_busy, tx_line;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_tx #(.CLKS_PER_BIT(C)) uut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_send(tx_send),
        .cfg_invert(cfg_invert), .cfg_msb_first(cfg_msb_first),
        .cfg_seven_bit(cfg_seven_bit), .cfg_parity(cfg_parity),
        .tx_busy(tx_busy), .tx_line(tx_line)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Send one frame and check every bit centre. scramble: disturb inputs mid-frame.
    task automatic send_frame(input string tag, input logic [7:0] d, input logic inv,
                              input logic msb, input logic seven, input logic [1:0] par,
                              input bit scramble);
        int  nbits;
        int  ones;
        logic lv [0:10];
        int  total;
        nbits = seven ? 7 : 8;
        ones  = 0;
        lv[0] = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            lv[1+i] = msb ? d[nbits-1-i] : d[i];
            ones += lv[1+i];
        end
        total = 1 + nbits;
        if (par == 2'b01) begin lv[total] = (ones % 2) == 1; total++; end
        else if (par == 2'b10) begin lv[total] = (ones % 2) == 0; total++; end
        lv[total] = 1'b1;
        total++;

        @(negedge clk);
        tx_data = d; cfg_invert = inv; cfg_msb_first = msb;
        cfg_seven_bit = seven; cfg_parity = par; tx_send = 1'b1;
        check({tag, " R9 busy low before accept"}, tx_busy, 0);
        @(posedge clk);
        #2;
        if (scramble) begin
            tx_data = ~d; cfg_msb_first = ~msb; cfg_seven_bit = ~seven;
            cfg_parity = par ^ 2'b11; cfg_invert = ~inv;
        end else begin
            tx_send = 1'b0;
        end
        for (int b = 0; b < total; b++) begin
            repeat (C/2) @(posedge clk);
            @(negedge clk);
            check({tag, (scramble ? " R10" : " R1"), " busy in frame"}, tx_busy, 1);
            check({tag, (b == 0 ? " R2 start" : (b <= nbits ? (msb ? " R5 data" : " R4 data")
                         : (b == total-1 ? " R8 stop" : " R7 parity"))), " R3 level"},
                  tx_line, lv[b] ^ inv);
            repeat (C - C/2) @(posedge clk);
        end
        @(negedge clk);
        tx_send = 1'b0; tx_data = d; cfg_invert = inv; cfg_msb_first = msb;
        cfg_seven_bit = seven; cfg_parity = par;
        check({tag, " R1 busy low after stop"}, tx_busy, 0);
        check({tag, " R2 idle ON"}, tx_line, !inv);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 busy after reset", tx_busy, 0);
        check("R11 line after reset", tx_line, 1);
    endtask

    task automatic t_idle_pol();
        @(negedge clk); cfg_invert = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 inverted idle low", tx_line, 0);
        cfg_invert = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 normal idle high", tx_line, 1);
    endtask

    task automatic t_lsb8_none();  send_frame("lsb8", 8'hA5, 0, 0, 0, 2'b00, 0); endtask
    task automatic t_msb8_even();  send_frame("msb8e", 8'h93, 0, 1, 0, 2'b01, 0); endtask
    task automatic t_msb7_odd();   send_frame("msb7o", 8'h41, 0, 1, 1, 2'b10, 0); endtask
    task automatic t_bit7_ignored();
        // R6: bit 7 set but 7-bit mode; even parity over bits 6..0 only
        send_frame("R6 seven", 8'hB2, 0, 0, 1, 2'b01, 0);
        send_frame("R6 seven ff", 8'hFF, 0, 1, 1, 2'b10, 0);
    endtask
    task automatic t_inverted();   send_frame("inv", 8'h3C, 1, 0, 0, 2'b10, 0); endtask
    task automatic t_none11();     send_frame("R7 mode11", 8'h01, 0, 0, 0, 2'b11, 0); endtask
    task automatic t_midframe();   send_frame("R10 scramble", 8'h6D, 0, 0, 0, 2'b01, 1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_pol();
        t_lsb8_none();
        t_msb8_even();
        t_msb7_odd();
        t_bit7_ignored();
        t_inverted();
        t_none11();
        t_midframe();
        t_lsb8_none();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule